// File: doc/BRIEF.md
# Serial Port Register Front-End

This block is the register file that a processor sees when it talks to a simple serial port. It decodes single-cycle, word-aligned reads and writes on a 6-bit offset into eleven register slots. Line format and baud divisor values are only stored and read back for a bit engine elsewhere. A byte written to the transmit slot either leaves on a valid-qualified byte output or, when the loopback control bit is set, is placed in a one-byte receive holding register. That holding register is also filled from an incoming byte stream with a ready/valid handshake. The stream is only accepted while the holding register is empty.

Each direction has its own interrupt, and a control bit selects the style for each. In pulse style the interrupt is a one-clock strobe. In level style it is a held line that is cleared by a defined bus action. Status slots report fixed encodings that reflect a transmitter that is always empty and a receive store that holds zero or one byte.

Top module: `uart_regfront`

## Requirements
- R1: After reset, every stored register and the byte-held flag are zero: `bus_rdata`, `tx_valid` and all four interrupt outputs are 0, and `rx_ready` is 1.
- R2: The line-format slot (0x00), the control slot (0x04) and the divisor slot (0x28) store all 32 written bits and read them back unchanged. Read data is registered and appears in the cycle after the read request.
- R3: The queue-setup slot (0x08) stores the written word with bits 1 and 2 cleared, and it reads back with bit 3 forced to 0.
- R4: The line-signal slot (0x0C) reads back only bits 0 and 4 of the last written value, with all other bits 0.
- R5: The transfer-status slot (0x10) reads 0b110 ORed with the byte-held flag in bit 0. The queue-level slot (0x18) reads the byte-held flag as a count of 0 or 1.
- R6: The fault slot (0x14), the line-status slot (0x1C), the transmit slot (0x20) and unmapped offsets read 0. Writes to 0x10, 0x14, 0x18, 0x1C and 0x24 change no output and no readback.
- R7: When control bit 5 is 0, a write to 0x20 makes `tx_valid` high for exactly the next cycle, with `tx_data` equal to the written bits 7:0.
- R8: When control bit 5 is 1, a write to 0x20 produces no `tx_valid`. Instead, bits 7:0 are stored as the held receive byte and the byte-held flag is set.
- R9: `rx_ready` is the inverse of the byte-held flag. A byte offered while a byte is held is not taken and does not replace the held byte.
- R10: A read of 0x24 returns the held byte and clears the byte-held flag.
- R11: When control bit 8 is 0, each byte that enters the holding register gives a one-cycle `rx_irq_pulse`. When bit 8 is 1, it sets `rx_irq_level` instead. The level is cleared by a read of 0x24 while bit 8 is 1, or by any control write with bit 8 equal to 0.
- R12: A control write copies its bit 9 into `tx_irq_level`. Each write to 0x20 sets `tx_irq_level` when control bit 9 is 1, and otherwise gives a one-cycle `tx_irq_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | One-cycle strobe qualifying `tx_data` |
| rx_data | input | 8 | Incoming byte |
| rx_valid | input | 1 | Incoming byte offered |
| rx_ready | output | 1 | Block can take a byte |
| tx_irq_pulse | output | 1 | Transmit interrupt, pulse style |
| tx_irq_level | output | 1 | Transmit interrupt, level style |
| rx_irq_pulse | output | 1 | Receive interrupt, pulse style |
| rx_irq_level | output | 1 | Receive interrupt, level style |

## Verification
Every result of this block is registered exactly once. Read data, the transmit strobe, interrupt changes and the held-flag change all become visible in the cycle that follows the clock edge that samples the request. The bench drives each request on a falling edge and holds it across one rising edge. It then samples on the next falling edge, where all of those results are due. To prove that the pulses last only one cycle, it samples one falling edge later again. A byte offered while `rx_ready` is low is checked by reading the holding register back afterwards.

// File: rtl/uart_regfront_pkg.sv
package uart_regfront_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam int BYTE_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    OFS_LINE  = 6'h00,
    OFS_CTRL  = 6'h04,
    OFS_QCFG  = 6'h08,
    OFS_LSIG  = 6'h0C,
    OFS_XSTAT = 6'h10,
    OFS_FAULT = 6'h14,
    OFS_QLVL  = 6'h18,
    OFS_LSTAT = 6'h1C,
    OFS_TXD   = 6'h20,
    OFS_RXD   = 6'h24,
    OFS_DIV   = 6'h28
  } ofs_e;

  // control bit positions (software-visible)
  localparam int CTRL_LOOP  = 5;
  localparam int CTRL_RXLVL = 8;
  localparam int CTRL_TXLVL = 9;
endpackage

// File: rtl/uart_rf_store.sv
module uart_rf_store
  import uart_regfront_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_line,
  input  logic          we_ctrl,
  input  logic          we_qcfg,
  input  logic          we_lsig,
  input  logic          we_div,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] line_q,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] qcfg_q,
  output logic [1:0]    lsig_q,
  output logic [DW-1:0] div_q
);
  localparam logic [DW-1:0] QCFG_KEEP = ~DW'(32'h0000_000E);

  logic [DW-1:0] line_d, ctrl_d, qcfg_d, div_d;
  logic [1:0]    lsig_d;

  always_comb begin
    line_d = we_line ? wdata : line_q;
    ctrl_d = we_ctrl ? wdata : ctrl_q;
    qcfg_d = we_qcfg ? (wdata & QCFG_KEEP) : qcfg_q;
    lsig_d = we_lsig ? {wdata[4], wdata[0]} : lsig_q;
    div_d  = we_div  ? wdata : div_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      ctrl_q <= '0;
      qcfg_q <= '0;
      lsig_q <= '0;
      div_q  <= '0;
    end else begin
      line_q <= line_d;
      ctrl_q <= ctrl_d;
      qcfg_q <= qcfg_d;
      lsig_q <= lsig_d;
      div_q  <= div_d;
    end
  end
endmodule

// File: rtl/uart_rf_rxhold.sv
module uart_rf_rxhold
  import uart_regfront_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strm_valid,
  input  logic [BW-1:0] strm_byte,
  input  logic          lb_load,
  input  logic [BW-1:0] lb_byte,
  input  logic          take,
  output logic          held_q,
  output logic [BW-1:0] byte_q,
  output logic          arrive
);
  logic          strm_acc;
  logic          held_d;
  logic [BW-1:0] byte_d;

  assign strm_acc = strm_valid & ~held_q;
  assign arrive   = strm_acc | lb_load;

  always_comb begin
    held_d = held_q;
    byte_d = byte_q;
    if (strm_acc) begin
      byte_d = strm_byte;
      held_d = 1'b1;
    end else if (lb_load) begin
      byte_d = lb_byte;
      held_d = 1'b1;
    end else if (take) begin
      held_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      byte_q <= '0;
    end else begin
      held_q <= held_d;
      byte_q <= byte_d;
    end
  end
endmodule

// File: rtl/uart_rf_irq.sv
module uart_rf_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_lvl_mode,
  input  logic tx_lvl_mode,
  input  logic ctrl_wr,
  input  logic ctrl_wr_rxlvl,
  input  logic ctrl_wr_txlvl,
  input  logic rx_arrive,
  input  logic rx_take,
  input  logic tx_wr,
  output logic rx_pulse_q,
  output logic rx_level_q,
  output logic tx_pulse_q,
  output logic tx_level_q
);
  logic rx_pulse_d, rx_level_d, tx_pulse_d, tx_level_d;

  always_comb begin
    rx_pulse_d = rx_arrive & ~rx_lvl_mode;
    tx_pulse_d = tx_wr & ~tx_lvl_mode;

    rx_level_d = rx_level_q;
    if (ctrl_wr && !ctrl_wr_rxlvl)       rx_level_d = 1'b0;
    else if (rx_arrive && rx_lvl_mode)   rx_level_d = 1'b1;
    else if (rx_take && rx_lvl_mode)     rx_level_d = 1'b0;

    tx_level_d = tx_level_q;
    if (ctrl_wr)                         tx_level_d = ctrl_wr_txlvl;
    else if (tx_wr && tx_lvl_mode)       tx_level_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_pulse_q <= 1'b0;
      rx_level_q <= 1'b0;
      tx_pulse_q <= 1'b0;
      tx_level_q <= 1'b0;
    end else begin
      rx_pulse_q <= rx_pulse_d;
      rx_level_q <= rx_level_d;
      tx_pulse_q <= tx_pulse_d;
      tx_level_q <= tx_level_d;
    end
  end
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_regfront_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic              tx_irq_pulse,
  output logic              tx_irq_level,
  output logic              rx_irq_pulse,
  output logic              rx_irq_level
);
  localparam logic [DATA_W-1:0] XSTAT_FIXED = DATA_W'(6);
  localparam logic [DATA_W-1:0] QCFG_RDMASK = ~DATA_W'(8);

  logic wr_hit, rd_hit;
  logic we_line, we_ctrl, we_qcfg, we_lsig, we_div, we_txd;
  logic loop_en, lb_load, out_send, rx_take, rx_arrive, held;
  logic [DATA_W-1:0] line_q, ctrl_q, qcfg_q, div_q;
  logic [1:0]        lsig_q;
  logic [BYTE_W-1:0] held_byte;
  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic              txv_d, txv_q;
  logic [BYTE_W-1:0] txd_d, txd_q;

  assign wr_hit  = bus_sel & bus_wr;
  assign rd_hit  = bus_sel & ~bus_wr;
  assign we_line = wr_hit && (bus_addr == OFS_LINE);
  assign we_ctrl = wr_hit && (bus_addr == OFS_CTRL);
  assign we_qcfg = wr_hit && (bus_addr == OFS_QCFG);
  assign we_lsig = wr_hit && (bus_addr == OFS_LSIG);
  assign we_div  = wr_hit && (bus_addr == OFS_DIV);
  assign we_txd  = wr_hit && (bus_addr == OFS_TXD);
  assign rx_take = rd_hit && (bus_addr == OFS_RXD);

  assign loop_en  = ctrl_q[CTRL_LOOP];
  assign lb_load  = we_txd & loop_en;
  assign out_send = we_txd & ~loop_en;

  uart_rf_store #(.DW(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we_line(we_line), .we_ctrl(we_ctrl), .we_qcfg(we_qcfg),
    .we_lsig(we_lsig), .we_div(we_div), .wdata(bus_wdata),
    .line_q(line_q), .ctrl_q(ctrl_q), .qcfg_q(qcfg_q),
    .lsig_q(lsig_q), .div_q(div_q)
  );

  uart_rf_rxhold #(.BW(BYTE_W)) u_rxhold (
    .clk(clk), .rst_n(rst_n),
    .strm_valid(rx_valid), .strm_byte(rx_data),
    .lb_load(lb_load), .lb_byte(bus_wdata[BYTE_W-1:0]),
    .take(rx_take), .held_q(held), .byte_q(held_byte),
    .arrive(rx_arrive)
  );

  uart_rf_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .rx_lvl_mode(ctrl_q[CTRL_RXLVL]), .tx_lvl_mode(ctrl_q[CTRL_TXLVL]),
    .ctrl_wr(we_ctrl),
    .ctrl_wr_rxlvl(bus_wdata[CTRL_RXLVL]), .ctrl_wr_txlvl(bus_wdata[CTRL_TXLVL]),
    .rx_arrive(rx_arrive), .rx_take(rx_take), .tx_wr(we_txd),
    .rx_pulse_q(rx_irq_pulse), .rx_level_q(rx_irq_level),
    .tx_pulse_q(tx_irq_pulse), .tx_level_q(tx_irq_level)
  );

  // read multiplexer, captured only on a read request
  always_comb begin
    rdata_d = rdata_q;
    if (rd_hit) begin
      unique case (bus_addr)
        OFS_LINE:  rdata_d = line_q;
        OFS_CTRL:  rdata_d = ctrl_q;
        OFS_QCFG:  rdata_d = qcfg_q & QCFG_RDMASK;
        OFS_LSIG:  rdata_d = DATA_W'({lsig_q[1], 3'b000, lsig_q[0]});
        OFS_XSTAT: rdata_d = XSTAT_FIXED | DATA_W'(held);
        OFS_QLVL:  rdata_d = DATA_W'(held);
        OFS_RXD:   rdata_d = DATA_W'(held_byte);
        OFS_DIV:   rdata_d = div_q;
        default:   rdata_d = '0;
      endcase
    end
  end

  always_comb begin
    txv_d = out_send;
    txd_d = out_send ? bus_wdata[BYTE_W-1:0] : txd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      txv_q   <= 1'b0;
      txd_q   <= '0;
    end else begin
      rdata_q <= rdata_d;
      txv_q   <= txv_d;
      txd_q   <= txd_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign tx_valid  = txv_q;
  assign tx_data   = txd_q;
  assign rx_ready  = ~held;
endmodule

// File: rtl/uart_regfront_chk.sv
module uart_regfront_chk
  import uart_regfront_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic              tx_irq_pulse,
  input logic              rx_irq_pulse,
  input logic              rx_irq_level
);
  logic txd_wr, rxd_rd, xst_rd, acc;
  assign txd_wr = bus_sel && bus_wr && (bus_addr == OFS_TXD);
  assign rxd_rd = bus_sel && !bus_wr && (bus_addr == OFS_RXD);
  assign xst_rd = bus_sel && !bus_wr && (bus_addr == OFS_XSTAT);
  assign acc    = rx_valid && rx_ready;

  p_accept_fills_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !rx_ready);

  p_txvalid_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(txd_wr));

  p_txpulse_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq_pulse |-> $past(txd_wr));

  p_rxpulse_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq_pulse |-> $past(acc || txd_wr));

  p_level_needs_byte_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq_level |-> !rx_ready);

  p_read_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rxd_rd && !acc) |=> rx_ready);

  p_xstat_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xst_rd |=> (bus_rdata[2:1] == 2'b11 && bus_rdata[DATA_W-1:3] == '0));
endmodule

bind uart_regfront uart_regfront_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_irq_pulse(tx_irq_pulse),
  .rx_irq_pulse(rx_irq_pulse), .rx_irq_level(rx_irq_level)
);

// File: tb/tb_uart_regfront.sv
module tb_uart_regfront;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] A_LINE = 6'h00, A_CTRL = 6'h04, A_QCFG = 6'h08,
    A_LSIG = 6'h0C, A_XST = 6'h10, A_FLT = 6'h14, A_QLV = 6'h18,
    A_LST = 6'h1C, A_TXD = 6'h20, A_RXD = 6'h24, A_DIV = 6'h28;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_sel, bus_wr;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0]  tx_data, rx_data;
  logic tx_valid, rx_valid, rx_ready;
  logic tx_irq_pulse, tx_irq_level, rx_irq_pulse, rx_irq_level;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regfront dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_irq_pulse(tx_irq_pulse), .tx_irq_level(tx_irq_level),
    .rx_irq_pulse(rx_irq_pulse), .rx_irq_level(rx_irq_level)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 rdata", bus_rdata, 0);
    check("R1 outputs", {tx_valid, tx_irq_pulse, tx_irq_level, rx_irq_pulse, rx_irq_level}, 0);
    check("R1 ready", rx_ready, 1);
    rd(A_CTRL, v); check("R1 ctrl", v, 0);
    rd(A_DIV, v);  check("R1 div", v, 0);
    rd(A_QLV, v);  check("R1 level", v, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(A_LINE, 32'hDEAD_BEEF);
    wr(A_DIV, 32'h1234_5678);
    wr(A_CTRL, 32'hFFFF_FCDF); // loop and both level bits clear
    rd(A_LINE, v); check("R2 line", v, 32'hDEAD_BEEF);
    rd(A_DIV, v);  check("R2 div", v, 32'h1234_5678);
    rd(A_CTRL, v); check("R2 ctrl", v, 32'hFFFF_FCDF);
    @(negedge clk); check("R2 rdata held", bus_rdata, 32'hFFFF_FCDF);
    wr(A_CTRL, 0);
  endtask

  task automatic t_masks();
    logic [31:0] v;
    wr(A_QCFG, 32'hFFFF_FFFF); rd(A_QCFG, v); check("R3 qcfg all", v, 32'hFFFF_FFF1);
    wr(A_QCFG, 32'h0000_000E); rd(A_QCFG, v); check("R3 qcfg low", v, 0);
    wr(A_LSIG, 32'hFFFF_FFFF); rd(A_LSIG, v); check("R4 lsig", v, 32'h11);
    wr(A_LSIG, 32'h0000_0010); rd(A_LSIG, v); check("R4 lsig b4", v, 32'h10);
  endtask

  task automatic t_readonly();
    logic [31:0] v;
    wr(A_XST, 32'hFFFF_FFFF); wr(A_FLT, 32'hFFFF_FFFF); wr(A_QLV, 32'hFFFF_FFFF);
    wr(A_LST, 32'hFFFF_FFFF); wr(A_RXD, 32'hFFFF_FFFF);
    check("R6 no irq", {tx_valid, tx_irq_pulse, rx_irq_pulse, rx_irq_level}, 0);
    check("R6 ready kept", rx_ready, 1);
    rd(A_FLT, v); check("R6 fault", v, 0);
    rd(A_LST, v); check("R6 lstat", v, 0);
    rd(A_TXD, v); check("R6 txd", v, 0);
    rd(6'h2C, v); check("R6 unmapped", v, 0);
    rd(A_XST, v); check("R5 xstat empty", v, 6);
    rd(A_QLV, v); check("R5 qlvl empty", v, 0);
  endtask

  task automatic t_tx();
    wr(A_CTRL, 0);
    wr(A_TXD, 32'h0000_01A5);
    check("R7 valid", tx_valid, 1);
    check("R7 data", tx_data, 8'hA5);
    check("R12 pulse", tx_irq_pulse, 1);
    check("R12 level off", tx_irq_level, 0);
    @(negedge clk);
    check("R7 one cycle", tx_valid, 0);
    check("R12 pulse one cycle", tx_irq_pulse, 0);
  endtask

  task automatic t_tx_level();
    wr(A_CTRL, 32'h200);
    check("R12 ctrl sets level", tx_irq_level, 1);
    wr(A_CTRL, 0);
    check("R12 ctrl clears level", tx_irq_level, 0);
    wr(A_CTRL, 32'h200);
    wr(A_CTRL, 32'h200);
    wr(A_TXD, 32'h42);
    check("R12 level write", tx_irq_level, 1);
    check("R12 no pulse", tx_irq_pulse, 0);
    check("R7 sent", {tx_valid, tx_data}, 9'h142);
    wr(A_CTRL, 0);
    check("R12 cleared", tx_irq_level, 0);
  endtask

  task automatic t_rx_pulse();
    logic [31:0] v;
    wr(A_CTRL, 0);
    push(8'h3C);
    check("R11 pulse", rx_irq_pulse, 1);
    check("R9 not ready", rx_ready, 0);
    check("R11 no level", rx_irq_level, 0);
    @(negedge clk); check("R11 pulse one cycle", rx_irq_pulse, 0);
    rd(A_XST, v); check("R5 xstat held", v, 7);
    rd(A_QLV, v); check("R5 qlvl held", v, 1);
    push(8'h55);
    check("R9 refused no pulse", rx_irq_pulse, 0);
    rd(A_RXD, v); check("R10 byte", v, 8'h3C);
    check("R10 ready", rx_ready, 1);
    rd(A_XST, v); check("R10 xstat", v, 6);
  endtask

  task automatic t_rx_level();
    logic [31:0] v;
    wr(A_CTRL, 32'h100);
    push(8'h99);
    check("R11 level set", rx_irq_level, 1);
    check("R11 no pulse", rx_irq_pulse, 0);
    rd(A_RXD, v); check("R11 byte", v, 8'h99);
    check("R11 level cleared by read", rx_irq_level, 0);
    push(8'h66);
    check("R11 level again", rx_irq_level, 1);
    wr(A_CTRL, 0);
    check("R11 level cleared by ctrl", rx_irq_level, 0);
    check("R11 byte still held", rx_ready, 0);
    rd(A_RXD, v); check("R10 byte 2", v, 8'h66);
  endtask

  task automatic t_loop();
    logic [31:0] v;
    wr(A_CTRL, 32'h20);
    wr(A_TXD, 32'hFF77);
    check("R8 no tx", tx_valid, 0);
    check("R8 held", rx_ready, 0);
    check("R8 rx pulse", rx_irq_pulse, 1);
    check("R12 tx pulse", tx_irq_pulse, 1);
    rd(A_QLV, v); check("R8 qlvl", v, 1);
    rd(A_RXD, v); check("R8 byte", v, 8'h77);
    check("R8 freed", rx_ready, 1);
    wr(A_CTRL, 0);
  endtask

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; rx_data = '0; rx_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_masks();
    t_readonly();
    t_tx();
    t_tx_level();
    t_rx_pulse();
    t_rx_level();
    t_loop();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule